// File: doc/BRIEF.md
# Transmit Chunk Header Decoder

This block sits on the device side of a serial host link that carries Ethernet frames in fixed-size transmit chunks. Each chunk arrives as a byte stream: a 32-bit header, most significant byte first, followed by a fixed payload of 64 bytes. The block checks the header's odd parity and decodes its flags. It then picks out the payload bytes that belong to a frame and sends them on a byte stream. That stream carries start-of-frame, end-of-frame and abort markers and has no back-pressure.

The header marks a frame start by a validity flag and a 32-bit word offset into the payload. It marks a frame end by a second flag and the byte offset of the last frame byte. One payload can end one frame and start the next. A frame that is still open when a new start arrives is closed by an abort marker.

The block keeps a count of free chunk buffers, which are the transmit credits. A data chunk that is accepted takes one credit, and a pulse on the buffer-release input returns one. A data chunk that arrives with no credit left raises an overflow pulse and its payload is dropped.

Top module: `txchunk_decoder`

## Requirements
- R1: A byte with `in_valid` and `in_start` high is header bits 31..24, and the next three valid bytes complete the header in falling significance. The 64 valid bytes after the header are payload indices 0 to 63. Valid bytes outside a chunk are ignored, and a new `in_start` restarts the header at any time.
- R2: The header must hold an odd number of ones across all 32 bits. If it does not, `hdr_bad` pulses for one cycle in the cycle after the fourth header byte. No payload byte of that chunk is emitted, and the frame state is unchanged.
- R3: A data chunk with good parity, bit 31 = 1 and bit 21 = 1 that arrives while `tx_credits` is 0 raises `tx_overflow` for one cycle after its fourth header byte. Its payload is dropped and `tx_credits` stays 0.
- R4: After reset `tx_credits` equals MAX_CREDITS. It drops by one for each data chunk that is accepted. A `buf_free` pulse raises it by one, up to MAX_CREDITS. When both happen in one cycle it is unchanged.
- R5: A chunk is ignored and takes no credit when bit 21 (data valid) is 0 or bit 31 (data, not control) is 0.
- R6: When bit 20 (start valid) is set, the payload byte at index 4*SWO, where SWO is bits 19..16, is emitted with `fs_sof`. If no frame is open, the bytes before it are dropped.
- R7: When bit 14 (end valid) is set and a frame is open at that point, the byte at index EBO, where EBO is bits 13..8, is emitted with `fs_eof`. The frame then closes, and later bytes are dropped unless a start follows. An end flag with no frame open has no effect.
- R8: If both start and end are set and 4*SWO > EBO, the open frame ends at EBO and a new frame starts at 4*SWO in the same payload.
- R9: A start that arrives while a frame is still open asserts `fs_abort` together with the new frame's `fs_sof`.
- R10: For each good-parity data header, `hdr_done` pulses for one cycle after the fourth header byte. In that same cycle `hdr_seq` (bit 30), `hdr_norx` (bit 29) and `hdr_tsc` (bits 7..6) take the header's values, and they hold them until the next such header.
- R11: While a frame is open, every byte of an accepted payload that carries neither marker is emitted.
- R12: Each emitted byte appears on `fs_data` with `fs_valid` in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_start | input | 1 | Input byte is the first header byte of a chunk |
| in_data | input | 8 | Input byte |
| buf_free | input | 1 | One chunk buffer has been released |
| fs_valid | output | 1 | Frame byte is valid |
| fs_data | output | 8 | Frame byte |
| fs_sof | output | 1 | First byte of a frame |
| fs_eof | output | 1 | Last byte of a frame |
| fs_abort | output | 1 | The previously open frame was aborted |
| hdr_done | output | 1 | Good-parity data header decoded (pulse) |
| hdr_seq | output | 1 | Sequence bit of the last good data header |
| hdr_norx | output | 1 | No-receive bit of the last good data header |
| hdr_tsc | output | 2 | Timestamp request of the last good data header |
| hdr_bad | output | 1 | Header parity error (pulse) |
| tx_overflow | output | 1 | Data chunk arrived with no credit (pulse) |
| tx_credits | output | CW | Free chunk buffers |

## Verification
Every payload byte passes through one register. Its output is therefore read one clock after the edge that samples that byte, and the bench maps it back to the payload index it drove. The header results (`hdr_bad`, `hdr_done`, the held fields, `tx_overflow` and the new `tx_credits`) are all due one cycle after the fourth header byte. The bench captures them at exactly that sample. A credit returned by `buf_free` is read one cycle after the pulse.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam int HDR_BYTES = 4;
  localparam int OFS_W     = 6;

  typedef struct packed {
    logic       dnc;
    logic       seq;
    logic       norx;
    logic       dv;
    logic       sv;
    logic [3:0] swo;
    logic       ev;
    logic [5:0] ebo;
    logic [1:0] tsc;
  } hdr_t;

  function automatic logic odd_parity_ok(input logic [31:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/txc_hdr_unpack.sv
module txc_hdr_unpack
  import txc_pkg::*;
(
  input  logic [31:0] word,
  output hdr_t        fields,
  output logic        parity_ok
);

  always_comb begin
    fields.dnc  = word[31];
    fields.seq  = word[30];
    fields.norx = word[29];
    fields.dv   = word[21];
    fields.sv   = word[20];
    fields.swo  = word[19:16];
    fields.ev   = word[14];
    fields.ebo  = word[13:8];
    fields.tsc  = word[7:6];
    parity_ok   = odd_parity_ok(word);
  end

endmodule

// File: rtl/txc_credit.sv
module txc_credit #(
  parameter int MAX_CREDITS = 8,
  parameter int CW          = $clog2(MAX_CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] count,
  output logic          empty
);

  localparam logic [CW-1:0] FULL = CW'(MAX_CREDITS);

  logic [CW-1:0] count_q, count_d;
  logic          count_en;

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (take && !give) begin
      count_d  = count_q - 1'b1;
      count_en = 1'b1;
    end else if (give && !take && count_q != FULL) begin
      count_d  = count_q + 1'b1;
      count_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= FULL;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
  assign empty = (count_q == '0);

endmodule

// File: rtl/txc_slicer.sv
module txc_slicer
  import txc_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int IW            = $clog2(PAYLOAD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [IW-1:0]    idx,
  input  logic [7:0]       data,
  input  logic             sv,
  input  logic [3:0]       swo,
  input  logic             ev,
  input  logic [OFS_W-1:0] ebo,
  output logic             fs_valid,
  output logic [7:0]       fs_data,
  output logic             fs_sof,
  output logic             fs_eof,
  output logic             fs_abort
);

  logic          open_q, open_d;
  logic          at_start, at_end, emit;
  logic [IW-1:0] start_idx, end_idx;
  logic          vld_q, sof_q, eof_q, abt_q;
  logic [7:0]    dat_q;

  assign start_idx = IW'({swo, 2'b00});
  assign end_idx   = IW'(ebo);
  assign at_start  = sv && (idx == start_idx);
  assign at_end    = ev && (idx == end_idx);
  assign emit      = byte_en && (at_start || open_q);

  always_comb begin
    open_d = open_q;
    if (byte_en) begin
      if (at_start) begin
        open_d = !at_end;
      end else if (open_q && at_end) begin
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      abt_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      if (byte_en) begin
        open_q <= open_d;
      end
      vld_q <= emit;
      sof_q <= emit && at_start;
      eof_q <= emit && at_end;
      abt_q <= byte_en && at_start && open_q;
      if (byte_en) begin
        dat_q <= data;
      end
    end
  end

  assign fs_valid = vld_q;
  assign fs_data  = dat_q;
  assign fs_sof   = sof_q;
  assign fs_eof   = eof_q;
  assign fs_abort = abt_q;

endmodule

// File: rtl/txchunk_decoder.sv
module txchunk_decoder
  import txc_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int MAX_CREDITS   = 8,
  localparam int CW           = $clog2(MAX_CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [7:0]    in_data,
  input  logic          buf_free,
  output logic          fs_valid,
  output logic [7:0]    fs_data,
  output logic          fs_sof,
  output logic          fs_eof,
  output logic          fs_abort,
  output logic          hdr_done,
  output logic          hdr_seq,
  output logic          hdr_norx,
  output logic [1:0]    hdr_tsc,
  output logic          hdr_bad,
  output logic          tx_overflow,
  output logic [CW-1:0] tx_credits
);

  localparam int            IW       = $clog2(PAYLOAD_BYTES);
  localparam int            SR_W     = 8 * (HDR_BYTES - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(PAYLOAD_BYTES - 1);
  localparam logic [1:0]    HDR_LAST = 2'(HDR_BYTES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_PAY} phase_e;

  phase_e           phase_q, phase_d;
  logic [1:0]       hcnt_q, hcnt_d;
  logic [SR_W-1:0]  hsr_q, hsr_d;
  logic [IW-1:0]    pidx_q, pidx_d;
  logic             take_q, take_d;
  logic             sv_q, sv_d, ev_q, ev_d;
  logic [3:0]       swo_q, swo_d;
  logic [OFS_W-1:0] ebo_q, ebo_d;
  logic             seq_q, seq_d, norx_q, norx_d;
  logic [1:0]       tsc_q, tsc_d;
  logic             done_q, bad_q, ovf_q;

  hdr_t        f;
  logic        par_ok;
  logic        is_start, hdr_fin, pay_en, data_hdr, want;
  logic        consume, ovf, cr_empty;
  logic [31:0] word;

  assign word = {hsr_q, in_data};

  txc_hdr_unpack u_unpack (
    .word      (word),
    .fields    (f),
    .parity_ok (par_ok)
  );

  assign is_start = in_valid && in_start;
  assign hdr_fin  = in_valid && !in_start && (phase_q == PH_HDR) && (hcnt_q == HDR_LAST);
  assign pay_en   = in_valid && !in_start && (phase_q == PH_PAY);
  assign data_hdr = hdr_fin && par_ok && f.dnc;
  assign want     = data_hdr && f.dv;
  assign consume  = want && !cr_empty;
  assign ovf      = want && cr_empty;

  always_comb begin
    phase_d = phase_q;
    hcnt_d  = hcnt_q;
    hsr_d   = hsr_q;
    pidx_d  = pidx_q;
    take_d  = take_q;
    sv_d    = sv_q;
    swo_d   = swo_q;
    ev_d    = ev_q;
    ebo_d   = ebo_q;
    seq_d   = seq_q;
    norx_d  = norx_q;
    tsc_d   = tsc_q;
    if (is_start) begin
      phase_d = PH_HDR;
      hcnt_d  = 2'd1;
      hsr_d   = {hsr_q[SR_W-9:0], in_data};
      take_d  = 1'b0;
    end else if (in_valid && phase_q == PH_HDR) begin
      hsr_d = {hsr_q[SR_W-9:0], in_data};
      if (hcnt_q == HDR_LAST) begin
        phase_d = PH_PAY;
        pidx_d  = '0;
        take_d  = consume;
        sv_d    = f.sv;
        swo_d   = f.swo;
        ev_d    = f.ev;
        ebo_d   = f.ebo;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end else if (pay_en) begin
      pidx_d = pidx_q + 1'b1;
      if (pidx_q == LAST_IDX) begin
        phase_d = PH_IDLE;
      end
    end
    if (data_hdr) begin
      seq_d  = f.seq;
      norx_d = f.norx;
      tsc_d  = f.tsc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hcnt_q  <= '0;
      hsr_q   <= '0;
      pidx_q  <= '0;
      take_q  <= 1'b0;
      sv_q    <= 1'b0;
      swo_q   <= '0;
      ev_q    <= 1'b0;
      ebo_q   <= '0;
      seq_q   <= 1'b0;
      norx_q  <= 1'b0;
      tsc_q   <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (in_valid) begin
        phase_q <= phase_d;
        hcnt_q  <= hcnt_d;
        hsr_q   <= hsr_d;
        pidx_q  <= pidx_d;
        take_q  <= take_d;
        sv_q    <= sv_d;
        swo_q   <= swo_d;
        ev_q    <= ev_d;
        ebo_q   <= ebo_d;
      end
      if (data_hdr) begin
        seq_q  <= seq_d;
        norx_q <= norx_d;
        tsc_q  <= tsc_d;
      end
      done_q <= data_hdr;
      bad_q  <= hdr_fin && !par_ok;
      ovf_q  <= ovf;
    end
  end

  txc_credit #(
    .MAX_CREDITS (MAX_CREDITS),
    .CW          (CW)
  ) u_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (consume),
    .give  (buf_free),
    .count (tx_credits),
    .empty (cr_empty)
  );

  txc_slicer #(
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .IW            (IW)
  ) u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_en  (pay_en && take_q),
    .idx      (pidx_q),
    .data     (in_data),
    .sv       (sv_q),
    .swo      (swo_q),
    .ev       (ev_q),
    .ebo      (ebo_q),
    .fs_valid (fs_valid),
    .fs_data  (fs_data),
    .fs_sof   (fs_sof),
    .fs_eof   (fs_eof),
    .fs_abort (fs_abort)
  );

  assign hdr_done    = done_q;
  assign hdr_seq     = seq_q;
  assign hdr_norx    = norx_q;
  assign hdr_tsc     = tsc_q;
  assign hdr_bad     = bad_q;
  assign tx_overflow = ovf_q;

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
  parameter int MAX_CREDITS = 8,
  parameter int CW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_start,
  input logic          fs_valid,
  input logic          fs_sof,
  input logic          fs_eof,
  input logic          fs_abort,
  input logic          hdr_done,
  input logic          hdr_bad,
  input logic          tx_overflow,
  input logic [CW-1:0] tx_credits
);

  logic drop_q;
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      if (in_valid && in_start) begin
        drop_q <= 1'b0;
      end else if (hdr_bad) begin
        drop_q <= 1'b1;
      end
      if (fs_valid) begin
        open_q <= fs_sof ? !fs_eof : (open_q && !fs_eof);
      end
    end
  end

  p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_credits <= CW'(MAX_CREDITS));

  p_credit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, tx_credits} == {1'b0, $past(tx_credits)}) ||
    ({1'b0, tx_credits} == {1'b0, $past(tx_credits)} + 1'b1) ||
    ({1'b0, tx_credits} + 1'b1 == {1'b0, $past(tx_credits)}));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |-> (tx_credits == '0) && ($past(tx_credits) == '0));

  p_bad_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad |-> !hdr_done && !tx_overflow);

  p_bad_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> !drop_q);

  p_abort_on_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fs_abort |-> fs_sof && fs_valid);

  p_bytes_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_valid |-> open_q || fs_sof);

  p_eof_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fs_eof |-> fs_valid && (open_q || fs_sof));

endmodule

bind txchunk_decoder txc_checker #(
  .MAX_CREDITS (MAX_CREDITS),
  .CW          (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_start    (in_start),
  .fs_valid    (fs_valid),
  .fs_sof      (fs_sof),
  .fs_eof      (fs_eof),
  .fs_abort    (fs_abort),
  .hdr_done    (hdr_done),
  .hdr_bad     (hdr_bad),
  .tx_overflow (tx_overflow),
  .tx_credits  (tx_credits)
);

// File: tb/txchunk_decoder_bench.sv
module txchunk_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXC       = 8;
  localparam int CW         = 4;
  localparam int NV         = 12;

  typedef struct packed {
    logic       dnc;
    logic       seq;
    logic       norx;
    logic       dv;
    logic       sv;
    logic [3:0] swo;
    logic       ev;
    logic [5:0] ebo;
    logic [1:0] tsc;
    logic       badp;
    logic [7:0] nbytes;
    logic [7:0] sofi;
    logic [7:0] eofi;
    logic [1:0] nab;
  } vec_t;

  // dnc seq norx dv sv swo ev ebo tsc badp | bytes sof eof aborts
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 6'd63, 2'd0, 1'b0, 8'd64, 8'd0,   8'd63,  2'd0}, // R6 R7 full frame
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2,  1'b0, 6'd0,  2'd1, 1'b0, 8'd56, 8'd8,   8'hFF,  2'd0}, // R6 start at 8
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  1'b0, 6'd0,  2'd2, 1'b0, 8'd64, 8'hFF,  8'hFF,  2'd0}, // R11 continuation
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 6'd3,  2'd3, 1'b0, 8'd0,  8'hFF,  8'hFF,  2'd0}, // R5 DV clear
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b1, 6'd5,  2'd0, 1'b1, 8'd0,  8'hFF,  8'hFF,  2'd0}, // R2 bad parity
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 6'd7,  2'd0, 1'b0, 8'd0,  8'hFF,  8'hFF,  2'd0}, // R5 control
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4,  1'b1, 6'd9,  2'd0, 1'b0, 8'd58, 8'd16,  8'd9,   2'd0}, // R8 end then start
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  1'b0, 6'd0,  2'd1, 1'b0, 8'd64, 8'd4,   8'hFF,  2'd1}, // R9 abort
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  1'b1, 6'd0,  2'd0, 1'b0, 8'd1,  8'hFF,  8'd0,   2'd0}, // R7 end at 0
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b1, 6'd20, 2'd0, 1'b0, 8'd0,  8'hFF,  8'hFF,  2'd0}, // R7 stray end
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd15, 1'b1, 6'd61, 2'd2, 1'b0, 8'd2,  8'd60,  8'd61,  2'd0}, // R6 late start
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 6'd0,  2'd3, 1'b0, 8'd1,  8'd0,   8'd0,   2'd0}  // R7 one-byte frame
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_start;
  logic [7:0]    in_data;
  logic          buf_free;
  logic          fs_valid;
  logic [7:0]    fs_data;
  logic          fs_sof;
  logic          fs_eof;
  logic          fs_abort;
  logic          hdr_done;
  logic          hdr_seq;
  logic          hdr_norx;
  logic [1:0]    hdr_tsc;
  logic          hdr_bad;
  logic          tx_overflow;
  logic [CW-1:0] tx_credits;

  txchunk_decoder #(
    .PAYLOAD_BYTES (64),
    .MAX_CREDITS   (MAXC)
  ) u_txchunk_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_start    (in_start),
    .in_data     (in_data),
    .buf_free    (buf_free),
    .fs_valid    (fs_valid),
    .fs_data     (fs_data),
    .fs_sof      (fs_sof),
    .fs_eof      (fs_eof),
    .fs_abort    (fs_abort),
    .hdr_done    (hdr_done),
    .hdr_seq     (hdr_seq),
    .hdr_norx    (hdr_norx),
    .hdr_tsc     (hdr_tsc),
    .hdr_bad     (hdr_bad),
    .tx_overflow (tx_overflow),
    .tx_credits  (tx_credits)
  );

  int         n_checks = 0;
  int         n_fail   = 0;
  int         got_n, got_sof, got_eof, got_ab, data_err;
  logic [7:0] cur_idx;
  logic       hb_bad, hb_done, hb_seq, hb_norx, hb_ovf;
  logic [1:0] hb_tsc;
  int         hb_cred;
  int         exp_cred;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (fs_valid) begin
      got_n++;
      if (fs_data !== cur_idx) data_err++;
      if (fs_sof) got_sof = int'(cur_idx);
      if (fs_eof) got_eof = int'(cur_idx);
      if (fs_abort) got_ab++;
    end
  endtask

  function automatic logic [31:0] mkhdr(input vec_t v);
    logic [31:0] h;
    h = {v.dnc, v.seq, v.norx, 5'b0, 2'b0, v.dv, v.sv, v.swo, 1'b0, v.ev, v.ebo, v.tsc, 5'b0, 1'b0};
    h[0] = ~(^h[31:1]) ^ v.badp;
    return h;
  endfunction

  task automatic send_chunk(input logic [31:0] h, input bit free_last);
    got_n = 0; got_sof = 255; got_eof = 255; got_ab = 0; data_err = 0;
    for (int b = 0; b < 4; b++) begin
      in_valid = 1'b1;
      in_start = (b == 0);
      in_data  = h[31-8*b -: 8];
      buf_free = free_last && (b == 3);
      cur_idx  = 8'hEE;
      tick();
    end
    hb_bad  = hdr_bad;
    hb_done = hdr_done;
    hb_seq  = hdr_seq;
    hb_norx = hdr_norx;
    hb_tsc  = hdr_tsc;
    hb_ovf  = tx_overflow;
    hb_cred = int'(tx_credits);
    buf_free = 1'b0;
    for (int i = 0; i < 64; i++) begin
      in_start = 1'b0;
      in_data  = 8'(i);
      cur_idx  = 8'(i);
      tick();
    end
    in_valid = 1'b0;
    cur_idx  = 8'hEE;
    tick();
  endtask

  task automatic pulse_free();
    buf_free = 1'b1;
    tick();
    buf_free = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    vec_t        v;
    logic [31:0] h;
    bit          acc;
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_data = '0; buf_free = 1'b0;
    cur_idx = 8'hEE;
    repeat (3) @(posedge clk);
    #1;
    check(tx_credits == CW'(MAXC), "R4 reset credits", int'(tx_credits), MAXC);
    check(!fs_valid && !hdr_bad && !tx_overflow && !hdr_done, "R12 reset outputs idle",
          int'({fs_valid, hdr_bad, tx_overflow, hdr_done}), 0);
    rst_n = 1'b1;
    exp_cred = MAXC;
    tick();

    for (int k = 0; k < NV; k++) begin
      v   = VECS[k];
      h   = mkhdr(v);
      acc = !v.badp && v.dnc && v.dv;
      send_chunk(h, 1'b0);
      check(hb_bad == v.badp, $sformatf("R2 hdr_bad vec %0d", k), int'(hb_bad), int'(v.badp));
      check(hb_done == (!v.badp && v.dnc), $sformatf("R10 hdr_done vec %0d", k),
            int'(hb_done), int'(!v.badp && v.dnc));
      if (!v.badp && v.dnc)
        check({hb_seq, hb_norx, hb_tsc} == {v.seq, v.norx, v.tsc}, $sformatf("R10 fields vec %0d", k),
              int'({hb_seq, hb_norx, hb_tsc}), int'({v.seq, v.norx, v.tsc}));
      if (acc) exp_cred--;
      check(hb_cred == exp_cred, $sformatf("R4 credits after header vec %0d", k), hb_cred, exp_cred);
      check(got_n == int'(v.nbytes), $sformatf("R6 R7 R11 byte count vec %0d", k), got_n, int'(v.nbytes));
      check(got_sof == int'(v.sofi), $sformatf("R6 sof index vec %0d", k), got_sof, int'(v.sofi));
      check(got_eof == int'(v.eofi), $sformatf("R7 R8 eof index vec %0d", k), got_eof, int'(v.eofi));
      check(got_ab == int'(v.nab), $sformatf("R9 abort count vec %0d", k), got_ab, int'(v.nab));
      check(data_err == 0, $sformatf("R1 R12 data and latency vec %0d", k), data_err, 0);
      if (acc) begin
        pulse_free();
        exp_cred++;
        check(int'(tx_credits) == exp_cred, $sformatf("R4 credit returned vec %0d", k),
              int'(tx_credits), exp_cred);
      end
    end

    // R1: valid bytes outside a chunk are ignored
    got_n = 0;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_start = 1'b0; in_data = 8'(i); cur_idx = 8'(i);
      tick();
    end
    in_valid = 1'b0;
    tick();
    check(got_n == 0, "R1 stray bytes ignored", got_n, 0);

    // R4: saturation at the maximum
    pulse_free();
    check(int'(tx_credits) == MAXC, "R4 saturate at max", int'(tx_credits), MAXC);

    // R4: take and give in the same cycle
    send_chunk(mkhdr('{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 6'd63, 2'd0, 1'b0,
                       8'd0, 8'd0, 8'd0, 2'd0}), 1'b1);
    check(hb_cred == MAXC, "R4 simultaneous take and give", hb_cred, MAXC);
    check(got_n == 64, "R6 R7 frame with simultaneous release", got_n, 64);

    // R3: drain all credits, then overflow
    for (int d = 0; d < MAXC; d++) begin
      send_chunk(mkhdr('{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 6'd0, 2'd0, 1'b0,
                         8'd0, 8'd0, 8'd0, 2'd0}), 1'b0);
      check(hb_cred == MAXC - 1 - d, "R4 drain step", hb_cred, MAXC - 1 - d);
      check(!hb_ovf, "R3 no overflow while credit left", int'(hb_ovf), 0);
    end
    send_chunk(mkhdr('{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 6'd63, 2'd0, 1'b0,
                       8'd0, 8'd0, 8'd0, 2'd0}), 1'b0);
    check(hb_ovf, "R3 overflow raised", int'(hb_ovf), 1);
    check(hb_cred == 0, "R3 credits stay zero", hb_cred, 0);
    check(got_n == 0, "R3 overflow payload dropped", got_n, 0);
    pulse_free();
    check(int'(tx_credits) == 1, "R4 one credit returned", int'(tx_credits), 1);
    send_chunk(mkhdr('{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 6'd63, 2'd0, 1'b0,
                       8'd0, 8'd0, 8'd0, 2'd0}), 1'b0);
    check(!hb_ovf && hb_cred == 0, "R3 last credit used without overflow", hb_cred, 0);
    check(got_n == 64 && got_sof == 0 && got_eof == 63, "R6 R7 frame after refill", got_n, 64);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule